// File: doc/BRIEF.md
# Run-Time Programmable Sum-of-Products Array

This block evaluates several sum-of-products functions over one shared input vector. A product-term plane holds one general product per row. A sum plane picks, for each output, which rows are ORed into it. Unlike a lookup memory, where an address decoder makes exactly one row true, any number of rows (none, one or many) can be true for the same input. Rows can also be shared by several outputs, so the row budget applies to all outputs together.

Both planes are loaded at run time through a write port that sets one row per clock: its literal pattern and its output-select bits. The path from the inputs to the outputs is purely combinational. The outputs stay at zero until a one-way configuration-done flag is raised. After that the contents are frozen until reset. A fixed-sum mode keeps the product plane programmable. In that mode it ties each output to its own private, equal-sized band of rows, and the stored select bits are not used.

Top module: `pla_fabric`

## Requirements
- R1: After reset, `out_vec` is 0 and `cfg_done` is 0, with every row all-absent and every select bit cleared.
- R2: While `cfg_done` is 0, `out_vec` is 0 whatever the input and the stored contents.
- R3: Bits [2i+1:2i] of `cfg_and` give the literal of input i for that row: 2'b00 = input absent, 2'b01 = input must be 1, 2'b10 = input must be 0, 2'b11 = row is always false. A row is true when every one of its literals passes.
- R4: A row whose literals are all absent is true for every input.
- R5: In shared mode (`pal_mode` = 0), `out_vec[k]` is the OR of every true row whose select bit k was written as 1 (bit k of `cfg_or`). Any number of rows may be true at once.
- R6: A row whose select bits are all 0 has no effect on any output, and a row with an always-false literal never raises an output.
- R7: A write with `cfg_we` = 1 takes effect at the clock edge where it is sampled. This includes a write in the same cycle as `cfg_done_set`.
- R8: Once `cfg_done` is 1 it stays 1 until reset, and any later write changes nothing.
- R9: With `pal_mode` = 1, `out_vec[k]` is the OR of rows 6k to 6k+5, and writes leave the stored select bits unchanged. Product-plane writes still apply.
- R10: A write with a row index of 48 or more changes no row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pal_mode | input | 1 | 1 = fixed row bands per output; 0 = programmable select |
| cfg_we | input | 1 | Row write strobe |
| cfg_row | input | 6 | Row index of the write |
| cfg_and | input | 32 | Literal codes, two bits per input |
| cfg_or | input | 8 | Output-select bits of the row |
| cfg_done_set | input | 1 | Raises the configuration-done flag |
| in_vec | input | 16 | Shared input variables |
| out_vec | output | 8 | Function outputs |
| cfg_done | output | 1 | Configuration-done flag |

## Verification
A corrupted literal or select bit is not visible until the done flag is raised, because the outputs are held at zero before that. After the flag is raised, the fault shows on the first input vector that makes the affected row decide an output, in the same cycle. The most likely symptom is a single output bit that is wrong for only a small set of inputs. For that reason, random vectors applied to random sparse rows are compared bit by bit against a model. Directed cases cover the all-absent row, the always-false row, writes after the done flag, and out-of-range row indices.

// File: rtl/pla_pkg.sv
package pla_pkg;

    localparam int DEF_N_IN   = 16;
    localparam int DEF_N_TERM = 48;
    localparam int DEF_N_OUT  = 8;

    typedef enum logic [1:0] {
        LIT_ABSENT = 2'b00,
        LIT_TRUE   = 2'b01,
        LIT_COMP   = 2'b10,
        LIT_KILL   = 2'b11
    } lit_e;

    // One literal of a product row against one input bit.
    function automatic logic lit_pass(input lit_e code, input logic x);
        case (code)
            LIT_ABSENT: return 1'b1;
            LIT_TRUE:   return x;
            LIT_COMP:   return ~x;
            default:    return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/pla_cfg_ctrl.sv
module pla_cfg_ctrl #(
    parameter int N_TERM = pla_pkg::DEF_N_TERM,
    localparam int ROW_W = $clog2(N_TERM)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_we,
    input  logic [ROW_W-1:0] cfg_row,
    input  logic             cfg_done_set,
    output logic             wr_en,
    output logic             done
);

    always_ff @(posedge clk) begin
        if (rst)
            done <= 1'b0;
        else if (cfg_done_set)
            done <= 1'b1;
    end

    always_comb wr_en = cfg_we && !done && (int'(cfg_row) < N_TERM);

    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (rst)
        done |=> done); // R8

endmodule

// File: rtl/pla_and_plane.sv
module pla_and_plane
    import pla_pkg::*;
#(
    parameter int N_IN   = DEF_N_IN,
    parameter int N_TERM = DEF_N_TERM,
    localparam int ROW_W = $clog2(N_TERM),
    localparam int AND_W = 2 * N_IN
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              done,
    input  logic              cfg_we,
    input  logic [ROW_W-1:0]  cfg_row,
    input  logic [AND_W-1:0]  cfg_and,
    input  logic [N_IN-1:0]   in_vec,
    output logic [N_TERM-1:0] term
);

    logic [N_TERM-1:0][AND_W-1:0] rows;

    always_ff @(posedge clk) begin
        if (rst)
            rows <= '0;
        else if (wr_en)
            rows[cfg_row] <= cfg_and;
    end

    for (genvar t = 0; t < N_TERM; t++) begin : g_row
        logic [N_IN-1:0] pass;
        for (genvar i = 0; i < N_IN; i++) begin : g_lit
            always_comb pass[i] = lit_pass(lit_e'(rows[t][2*i +: 2]), in_vec[i]);
        end
        always_comb term[t] = &pass;
    end

    AST_AND_FROZEN: assert property (@(posedge clk) disable iff (rst)
        done |=> $stable(rows)); // R8

    AST_ROW_RANGE: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && int'(cfg_row) >= N_TERM) |=> $stable(rows)); // R10

endmodule

// File: rtl/pla_or_plane.sv
module pla_or_plane #(
    parameter int N_TERM = pla_pkg::DEF_N_TERM,
    parameter int N_OUT  = pla_pkg::DEF_N_OUT,
    localparam int ROW_W = $clog2(N_TERM),
    localparam int GRP   = N_TERM / N_OUT
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              pal_mode,
    input  logic [ROW_W-1:0]  cfg_row,
    input  logic [N_OUT-1:0]  cfg_or,
    input  logic [N_TERM-1:0] term,
    output logic [N_OUT-1:0]  sum
);

    logic [N_TERM-1:0][N_OUT-1:0] sel;

    always_ff @(posedge clk) begin
        if (rst)
            sel <= '0;
        else if (wr_en && !pal_mode)
            sel[cfg_row] <= cfg_or;
    end

    for (genvar k = 0; k < N_OUT; k++) begin : g_out
        logic [N_TERM-1:0] hit;
        logic              shared_sum;
        logic              band_sum;
        for (genvar t = 0; t < N_TERM; t++) begin : g_col
            always_comb hit[t] = term[t] & sel[t][k];
        end
        always_comb shared_sum = |hit;
        always_comb band_sum   = |term[k*GRP +: GRP];
        always_comb sum[k]     = pal_mode ? band_sum : shared_sum;

        AST_BAND_QUIET: assert property (@(posedge clk) disable iff (rst)
            (pal_mode && term[k*GRP +: GRP] == '0) |-> !sum[k]); // R9
    end

    AST_SEL_LOCKED: assert property (@(posedge clk) disable iff (rst)
        pal_mode |=> $stable(sel)); // R9

endmodule

// File: rtl/pla_fabric.sv
module pla_fabric
    import pla_pkg::*;
#(
    parameter int N_IN   = DEF_N_IN,
    parameter int N_TERM = DEF_N_TERM,
    parameter int N_OUT  = DEF_N_OUT,
    localparam int ROW_W = $clog2(N_TERM),
    localparam int AND_W = 2 * N_IN
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pal_mode,
    input  logic             cfg_we,
    input  logic [ROW_W-1:0] cfg_row,
    input  logic [AND_W-1:0] cfg_and,
    input  logic [N_OUT-1:0] cfg_or,
    input  logic             cfg_done_set,
    input  logic [N_IN-1:0]  in_vec,
    output logic [N_OUT-1:0] out_vec,
    output logic             cfg_done
);

    logic              wr_en;
    logic [N_TERM-1:0] term;
    logic [N_OUT-1:0]  sum;

    pla_cfg_ctrl #(.N_TERM(N_TERM)) u_ctrl (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_row(cfg_row),
        .cfg_done_set(cfg_done_set), .wr_en(wr_en), .done(cfg_done)
    );

    pla_and_plane #(.N_IN(N_IN), .N_TERM(N_TERM)) u_and (
        .clk(clk), .rst(rst), .wr_en(wr_en), .done(cfg_done),
        .cfg_we(cfg_we), .cfg_row(cfg_row), .cfg_and(cfg_and),
        .in_vec(in_vec), .term(term)
    );

    pla_or_plane #(.N_TERM(N_TERM), .N_OUT(N_OUT)) u_or (
        .clk(clk), .rst(rst), .wr_en(wr_en), .pal_mode(pal_mode),
        .cfg_row(cfg_row), .cfg_or(cfg_or), .term(term), .sum(sum)
    );

    always_comb out_vec = cfg_done ? sum : '0;

    AST_GATED_OFF: assert property (@(posedge clk) disable iff (rst)
        !cfg_done |-> out_vec == '0); // R2

endmodule

// File: tb/sim_pla_fabric.sv
module sim_pla_fabric;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        pal_mode = 1'b0;
    logic        cfg_we = 1'b0;
    logic [5:0]  cfg_row = '0;
    logic [31:0] cfg_and = '0;
    logic [7:0]  cfg_or = '0;
    logic        cfg_done_set = 1'b0;
    logic [15:0] in_vec = '0;
    logic [7:0]  out_vec;
    logic        cfg_done;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    bit [31:0] m_and [48];
    bit [7:0]  m_or  [48];
    bit        m_pal;

    always #10 clk = ~clk;

    pla_fabric u0 (
        .clk(clk), .rst(rst), .pal_mode(pal_mode), .cfg_we(cfg_we),
        .cfg_row(cfg_row), .cfg_and(cfg_and), .cfg_or(cfg_or),
        .cfg_done_set(cfg_done_set), .in_vec(in_vec),
        .out_vec(out_vec), .cfg_done(cfg_done)
    );

    function automatic bit m_term(int r, bit [15:0] x);
        bit ok = 1;
        for (int i = 0; i < 16; i++) begin
            case (m_and[r][2*i +: 2])
                2'b01: if (!x[i]) ok = 0;
                2'b10: if (x[i])  ok = 0;
                2'b11: ok = 0;
                default: ;
            endcase
        end
        return ok;
    endfunction

    function automatic bit [7:0] m_out(bit [15:0] x);
        bit [7:0] o = '0;
        for (int r = 0; r < 48; r++) begin
            if (m_term(r, x)) begin
                if (m_pal) o[r / 6] = 1'b1;
                else       o = o | m_or[r];
            end
        end
        return o;
    endfunction

    function automatic bit [31:0] rand_row();
        bit [31:0] w = '0;
        for (int i = 0; i < 16; i++) begin
            int u = $urandom % 20;
            if (u >= 19)      w[2*i +: 2] = 2'b11;
            else if (u >= 16) w[2*i +: 2] = 2'b10;
            else if (u >= 13) w[2*i +: 2] = 2'b01;
        end
        return w;
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(int row, bit [31:0] a, bit [7:0] o, bit dset);
        @(negedge clk);
        cfg_we = 1'b1; cfg_row = 6'(row); cfg_and = a; cfg_or = o;
        cfg_done_set = dset;
        @(negedge clk);
        cfg_we = 1'b0; cfg_done_set = 1'b0;
    endtask

    task automatic do_reset(bit pal);
        @(negedge clk);
        rst = 1'b1; pal_mode = pal; m_pal = pal;
        for (int r = 0; r < 48; r++) begin m_and[r] = '0; m_or[r] = '0; end
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic apply(string req, bit [15:0] x);
        @(negedge clk);
        in_vec = x;
        #2;
        check(req, 32'(out_vec), 32'(m_out(x)));
    endtask

    initial begin
        #(20 * 150000);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2741));

        // Shared-mode phase
        do_reset(1'b0);
        #2;
        check("R1 out", 32'(out_vec), 0);
        check("R1 done", 32'(cfg_done), 0);

        for (int r = 0; r < 45; r++) begin
            bit [31:0] a = rand_row();
            bit [7:0]  o = 8'($urandom) & 8'($urandom) & 8'h3F;
            m_and[r] = a; m_or[r] = o;
            wr(r, a, o, 1'b0);
        end
        // row 44: selected by nothing and always true -> no effect (R6)
        m_and[44] = '0; m_or[44] = '0; wr(44, '0, '0, 1'b0);
        // row 46: always-false literal on input 3, drives out6 (R6)
        m_and[46] = 32'h0000_00C0; m_or[46] = 8'h40; wr(46, 32'h0000_00C0, 8'h40, 1'b0);
        // out-of-range index must not alias onto a real row (R10)
        wr(50, '0, 8'hFF, 1'b0);
        wr(63, '0, 8'hFF, 1'b0);

        // before done: all outputs zero (R2)
        for (int n = 0; n < 6; n++) begin
            @(negedge clk); in_vec = 16'($urandom); #2;
            check("R2 gated", 32'(out_vec), 0);
        end

        // row 47 all-absent on out7, written with the done strobe (R4 R7)
        m_and[47] = '0; m_or[47] = 8'h80;
        wr(47, '0, 8'h80, 1'b1);
        #2;
        check("R7 done", 32'(cfg_done), 1);
        check("R4 R7 out7", 32'(out_vec[7]), 1);

        for (int n = 0; n < 300; n++) apply("R3 R5 R6 R10", 16'($urandom));
        apply("R3 R5 zeros", 16'h0000);
        apply("R3 R5 ones", 16'hFFFF);
        // out6 comes only from the killed row -> 0 (R6)
        @(negedge clk); in_vec = 16'h0008; #2;
        check("R6 killed row", 32'(out_vec[6]), 0);

        // writes after done are ignored (R8)
        wr(47, 32'hFFFF_FFFF, 8'h00, 1'b0);
        for (int r = 0; r < 44; r++) wr(r, '0, 8'hFF, 1'b0);
        #2;
        check("R8 done held", 32'(cfg_done), 1);
        for (int n = 0; n < 40; n++) apply("R8 frozen", 16'($urandom));

        // Fixed-band phase
        do_reset(1'b1);
        for (int r = 0; r < 48; r++) begin
            bit [31:0] a = rand_row();
            bit [7:0]  o = 8'($urandom);
            m_and[r] = a; m_or[r] = o;
            wr(r, a, o, 1'b0);
        end
        // band of out3 (rows 18..23) all killed -> out3 stays 0
        for (int r = 18; r < 24; r++) begin
            m_and[r] = 32'h3000_0000; wr(r, 32'h3000_0000, 8'hFF, 1'b0);
        end
        // row 0 all-absent with empty select: still drives out0 (R9 R7)
        m_and[0] = '0; m_or[0] = '0;
        wr(0, '0, 8'h00, 1'b1);
        #2;
        check("R9 R7 out0", 32'(out_vec[0]), 1);
        check("R9 out3", 32'(out_vec[3]), 0);
        for (int n = 0; n < 300; n++) apply("R9 R3", 16'($urandom));

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule